// File: doc/BRIEF.md
# Interpolated Half-Sine Low-Frequency Oscillator

This block produces a slow sinusoidal modulation word, one new value for each pulse on its sample strobe. A 32-bit phase register advances by a 16-bit rate on every strobe. Its upper half-word selects entries in a 512-entry table that holds half of a sine period. One phase bit supplies the sign, so the half-wave table covers the full cycle. The 16-bit fractional part of the phase blends each entry with its neighbour by linear interpolation. Because the phase is 32 bits wide, the slowest rates need billions of strobes per cycle.

The interpolated value is scaled by an unsigned 8-bit depth and appears as a signed 16-bit word with a valid pulse. A typical use is sweeping the read offset of a delay line. The circuit that supplies the rate and depth values lies outside this block. The rate and depth present at a strobe belong to that sample.

Top module: `lfo_interp_sine`

## Requirements
- R1: While rst_ni is low, the phase is zero and valid_o and mod_o are 0.
- R2: Each cycle with strobe_i high adds the zero-extended rate_i to the 32-bit phase. The phase does not change in cycles without a strobe.
- R3: Table entry k (0 to 511) equals round(32767 * sin(pi * k / 512)).
- R4: Let H be phase bits 31:16. Tap A reads entry H[8:0]. Tap B reads entry (H+1)[8:0], where H+1 wraps modulo 2^16.
- R5: Each tap is negated when bit 9 of its own half-word is 0 (H for tap A, H+1 for tap B). The tap is used unchanged when that bit is 1.
- R6: Let F be phase bits 15:0. The interpolated value is (A*(65535-F) + B*F) arithmetically shifted right by 16, taken as a signed 16-bit word.
- R7: mod_o is (interpolated value * depth) arithmetically shifted right by 8. The depth used is the depth_i value sampled together with the strobe, and depth 0 gives 0.
- R8: valid_o is high for exactly one cycle for each strobe. It becomes high on the third rising edge after the edge that sampled strobe_i. Back-to-back strobes give back-to-back valid cycles.
- R9: The phase wraps modulo 2^32 with no saturation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample strobe: advance phase and launch one output |
| rate_i | input | 16 | Phase increment per strobe |
| depth_i | input | 8 | Unsigned output scale |
| valid_o | output | 1 | Output word valid |
| mod_o | output | 16 | Signed modulation word |

## Verification
The bench uses the default parameters: a 32-bit phase, a 16-bit rate, a 9-bit table index and an 8-bit depth. With a 16-bit rate at full scale, the table boundary at half-word 511 to 512 is reached in a few hundred strobes, which exercises the sign change between tap A and tap B. About 65,540 back-to-back full-scale strobes carry the phase through its 32-bit wraparound. Zero-rate strobes separated by idle gaps show whether the phase holds between strobes.

// File: rtl/lfo_pkg.sv
package lfo_pkg;
  localparam int unsigned PHASE_W = 32;
  localparam int unsigned RATE_W  = 16;
  localparam int unsigned IDX_W   = 9;
  localparam int unsigned SAMP_W  = 16;
  localparam int unsigned DEPTH_W = 8;
  localparam real         PI_R    = 3.14159265358979323846;
  localparam real         AMP_R   = 32767.0;

  typedef logic signed [SAMP_W-1:0] samp_t;

  // half-wave entry k of n, rounded
  function automatic logic [SAMP_W-1:0] sine_entry(int k, int n);
    real a;
    a = AMP_R * $sin(PI_R * real'(k) / real'(n)) + 0.5;
    return SAMP_W'($rtoi(a));
  endfunction
endpackage

// File: rtl/lfo_phase_acc.sv
module lfo_phase_acc #(
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned RATE_W  = 16,
  parameter int unsigned DEPTH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic [RATE_W-1:0]  rate_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               valid_o
);
  localparam int unsigned PadW = PHASE_W - RATE_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      depth_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= strobe_i;
      if (strobe_i) begin
        phase_o <= phase_o + {{PadW{1'b0}}, rate_i};
        depth_o <= depth_i;
      end
    end
  end
endmodule

// File: rtl/lfo_sine_taps.sv
module lfo_sine_taps
  import lfo_pkg::*;
#(
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned SAMP_W  = 16,
  parameter int unsigned DEPTH_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [PHASE_W-1:0]       phase_i,
  input  logic [DEPTH_W-1:0]       depth_i,
  output logic signed [SAMP_W-1:0] tap_a_o,
  output logic signed [SAMP_W-1:0] tap_b_o,
  output logic [PHASE_W/2-1:0]     frac_o,
  output logic [DEPTH_W-1:0]       depth_o,
  output logic                     valid_o
);
  localparam int unsigned HalfW = PHASE_W / 2;
  localparam int unsigned Depth = 1 << IDX_W;

  logic [SAMP_W-1:0] rom [Depth];

  for (genvar g = 0; g < Depth; g++) begin : g_rom
    assign rom[g] = sine_entry(g, Depth);
  end

  logic [HalfW-1:0] hi_a, hi_b;
  logic signed [SAMP_W-1:0] raw_a, raw_b, sgn_a, sgn_b;

  assign hi_a  = phase_i[PHASE_W-1:HalfW];
  assign hi_b  = hi_a + HalfW'(1);
  assign raw_a = $signed(rom[hi_a[IDX_W-1:0]]);
  assign raw_b = $signed(rom[hi_b[IDX_W-1:0]]);
  // half-word bit IDX_W low selects the negative half
  assign sgn_a = hi_a[IDX_W] ? raw_a : -raw_a;
  assign sgn_b = hi_b[IDX_W] ? raw_b : -raw_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tap_a_o <= '0;
      tap_b_o <= '0;
      frac_o  <= '0;
      depth_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        tap_a_o <= sgn_a;
        tap_b_o <= sgn_b;
        frac_o  <= phase_i[HalfW-1:0];
        depth_o <= depth_i;
      end
    end
  end
endmodule

// File: rtl/lfo_interp.sv
module lfo_interp #(
  parameter int unsigned SAMP_W  = 16,
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned DEPTH_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [SAMP_W-1:0] tap_a_i,
  input  logic signed [SAMP_W-1:0] tap_b_i,
  input  logic [FRAC_W-1:0]        frac_i,
  input  logic [DEPTH_W-1:0]       depth_i,
  output logic signed [SAMP_W-1:0] interp_o,
  output logic [DEPTH_W-1:0]       depth_o,
  output logic                     valid_o
);
  localparam int unsigned ProdW = SAMP_W + FRAC_W + 1;
  localparam int unsigned SumW  = ProdW + 1;

  logic signed [FRAC_W:0]   w_a, w_b;
  logic signed [ProdW-1:0]  p_a, p_b;
  logic signed [SumW-1:0]   sum;
  logic signed [SumW-1:0]   shifted;

  // signed tap times unsigned weight
  assign w_a     = $signed({1'b0, ~frac_i});
  assign w_b     = $signed({1'b0, frac_i});
  assign p_a     = ProdW'(tap_a_i * w_a);
  assign p_b     = ProdW'(tap_b_i * w_b);
  assign sum     = SumW'(p_a) + SumW'(p_b);
  assign shifted = sum >>> FRAC_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      interp_o <= '0;
      depth_o  <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        interp_o <= shifted[SAMP_W-1:0];
        depth_o  <= depth_i;
      end
    end
  end
endmodule

// File: rtl/lfo_depth_scale.sv
module lfo_depth_scale #(
  parameter int unsigned SAMP_W  = 16,
  parameter int unsigned DEPTH_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [SAMP_W-1:0] value_i,
  input  logic [DEPTH_W-1:0]       depth_i,
  output logic signed [SAMP_W-1:0] mod_o,
  output logic                     valid_o
);
  localparam int unsigned ProdW = SAMP_W + DEPTH_W + 1;

  logic signed [DEPTH_W:0]  d_s;
  logic signed [ProdW-1:0]  prod;
  logic signed [ProdW-1:0]  scaled;

  assign d_s    = $signed({1'b0, depth_i});
  assign prod   = ProdW'(value_i * d_s);
  assign scaled = prod >>> DEPTH_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) mod_o <= scaled[SAMP_W-1:0];
    end
  end
endmodule

// File: rtl/lfo_interp_sine.sv
module lfo_interp_sine
  import lfo_pkg::*;
#(
  parameter int unsigned PHASE_W_P = PHASE_W,
  parameter int unsigned RATE_W_P  = RATE_W,
  parameter int unsigned IDX_W_P   = IDX_W,
  parameter int unsigned SAMP_W_P  = SAMP_W,
  parameter int unsigned DEPTH_W_P = DEPTH_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  strobe_i,
  input  logic [RATE_W_P-1:0]   rate_i,
  input  logic [DEPTH_W_P-1:0]  depth_i,
  output logic                  valid_o,
  output logic [SAMP_W_P-1:0]   mod_o
);
  localparam int unsigned FracW = PHASE_W_P / 2;

  logic [PHASE_W_P-1:0]       phase_q;
  logic [DEPTH_W_P-1:0]       dep_1, dep_2, dep_3;
  logic                       vld_1, vld_2, vld_3;
  logic signed [SAMP_W_P-1:0] tap_a, tap_b, interp;
  logic [FracW-1:0]           frac;
  logic signed [SAMP_W_P-1:0] mod_s;

  lfo_phase_acc #(
    .PHASE_W(PHASE_W_P), .RATE_W(RATE_W_P), .DEPTH_W(DEPTH_W_P)
  ) u_acc (
    .clk_i, .rst_ni, .strobe_i, .rate_i, .depth_i,
    .phase_o(phase_q), .depth_o(dep_1), .valid_o(vld_1)
  );

  lfo_sine_taps #(
    .PHASE_W(PHASE_W_P), .IDX_W(IDX_W_P), .SAMP_W(SAMP_W_P), .DEPTH_W(DEPTH_W_P)
  ) u_taps (
    .clk_i, .rst_ni, .valid_i(vld_1), .phase_i(phase_q), .depth_i(dep_1),
    .tap_a_o(tap_a), .tap_b_o(tap_b), .frac_o(frac), .depth_o(dep_2),
    .valid_o(vld_2)
  );

  lfo_interp #(
    .SAMP_W(SAMP_W_P), .FRAC_W(FracW), .DEPTH_W(DEPTH_W_P)
  ) u_interp (
    .clk_i, .rst_ni, .valid_i(vld_2), .tap_a_i(tap_a), .tap_b_i(tap_b),
    .frac_i(frac), .depth_i(dep_2), .interp_o(interp), .depth_o(dep_3),
    .valid_o(vld_3)
  );

  lfo_depth_scale #(
    .SAMP_W(SAMP_W_P), .DEPTH_W(DEPTH_W_P)
  ) u_scale (
    .clk_i, .rst_ni, .valid_i(vld_3), .value_i(interp), .depth_i(dep_3),
    .mod_o(mod_s), .valid_o(valid_o)
  );

  assign mod_o = mod_s;
endmodule

// File: rtl/lfo_interp_sine_chk.sv
module lfo_interp_sine_chk #(
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned RATE_W  = 16,
  parameter int unsigned SAMP_W  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               strobe_i,
  input logic [RATE_W-1:0]  rate_i,
  input logic               valid_o,
  input logic [SAMP_W-1:0]  mod_o,
  input logic [PHASE_W-1:0] phase_q
);
  logic [3:0] stb_hist;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_hist <= '0;
    else         stb_hist <= {stb_hist[2:0], strobe_i};
  end

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) reset_quiet_chk: assert (!valid_o && mod_o == '0 && phase_q == '0);
  end

  // R2
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(phase_q));

  // R2
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> phase_q == $past(phase_q) + PHASE_W'($past(rate_i)));

  // R8
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == stb_hist[3]);

  // R7
  mod_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> mod_o != {1'b1, {(SAMP_W-1){1'b0}}});
endmodule

bind lfo_interp_sine lfo_interp_sine_chk #(
  .PHASE_W(PHASE_W_P), .RATE_W(RATE_W_P), .SAMP_W(SAMP_W_P)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .rate_i(rate_i),
  .valid_o(valid_o), .mod_o(mod_o), .phase_q(phase_q)
);

// File: tb/sim_lfo_interp_sine.sv
`timescale 1ns/1ps
module sim_lfo_interp_sine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [15:0] rate_i = '0;
  logic [7:0]  depth_i = '0;
  logic        valid_o;
  logic [15:0] mod_o;

  lfo_interp_sine u0 (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic [15:0] val;
    int          cyc;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  logic [31:0] m_phase = '0;
  string       cur_tag = "R6";
  bit          done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // R3 reference entry
  function automatic longint tbl(int k);
    real a;
    a = 32767.0 * $sin(3.14159265358979323846 * real'(k) / 512.0) + 0.5;
    return longint'($rtoi(a));
  endfunction

  // R4, R5, R6, R7 reference output
  function automatic logic [15:0] model(logic [31:0] ph, logic [7:0] d);
    logic [15:0] h, h2, f;
    longint a, b, s, v;
    h  = ph[31:16];
    h2 = h + 16'd1;
    f  = ph[15:0];
    a  = tbl(int'(h[8:0]));
    b  = tbl(int'(h2[8:0]));
    if (!h[9])  a = -a;
    if (!h2[9]) b = -b;
    s = a * longint'(65535 - int'(f)) + b * longint'(f);
    s = s >>> 16;
    v = (s * longint'(d)) >>> 8;
    return v[15:0];
  endfunction

  task automatic send(logic [15:0] r, logic [7:0] d);
    item_t it;
    @(negedge clk_i);
    strobe_i = 1'b1;
    rate_i   = r;
    depth_i  = d;
    m_phase  = m_phase + {16'd0, r};   // R2, R9
    it.val = model(m_phase, d);
    it.cyc = cyc + 4;                  // R8
    it.tag = cur_tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    @(negedge clk_i);
    strobe_i = 1'b0;
    rate_i   = 16'hDEAD;
    depth_i  = 8'h5A;
    for (int i = 1; i < n; i++) @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      item_t it;
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL R8 unexpected valid: actual mod=%h expected none", mod_o);
      end else begin
        it = sb.pop_front();
        if (mod_o !== it.val) begin
          n_bad++;
          $display("FAIL %s mod_o actual=%h expected=%h", it.tag, mod_o, it.val);
        end
        n_chk++;
        if (cyc != it.cyc) begin
          n_bad++;
          $display("FAIL R8 valid cycle actual=%0d expected=%0d", cyc, it.cyc);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    n_chk++;
    if (valid_o !== 1'b0 || mod_o !== 16'h0) begin
      n_bad++;
      $display("FAIL R1 reset actual valid=%b mod=%h expected 0/0000", valid_o, mod_o);
    end
    rst_ni = 1'b1;
    idle(2);
    n_chk++;
    if (valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 idle after reset actual valid=%b expected 0", valid_o);
    end

    // R2 zero phase, holds across gaps
    cur_tag = "R2";
    send(16'h0000, 8'hFF);
    idle(5);
    send(16'h4000, 8'hFF);
    idle(7);
    send(16'h0000, 8'hFF);
    idle(3);
    send(16'h0000, 8'hFF);
    send(16'h0000, 8'hFF);

    // R3, R6 fine ramp, full depth
    cur_tag = "R6";
    for (int i = 0; i < 40; i++) send(16'h3A71, 8'hFF);
    idle(2);

    // R7 depth patterns, sampled with strobe
    cur_tag = "R7";
    for (int i = 0; i < 12; i++) send(16'h9C3F, 8'h00);
    for (int i = 0; i < 12; i++) send(16'h9C3F, 8'h80);
    for (int i = 0; i < 12; i++) send(16'h9C3F, 8'(i * 21 + 1));
    idle(4);

    // R4, R5 through the 511/512 table boundary and beyond
    cur_tag = "R5";
    for (int i = 0; i < 1200; i++) send(16'hFFFF, 8'hFF);
    cur_tag = "R3";
    for (int i = 0; i < 300; i++) send(16'h7FFF, 8'hC8);
    idle(3);

    // R9 32-bit wrap with full-scale rate
    cur_tag = "R9";
    for (int i = 0; i < 65540; i++) send(16'hFFFF, 8'hFF);
    idle(2);
    cur_tag = "R8";
    send(16'h1234, 8'h40);
    idle(1);
    send(16'h1234, 8'h40);
    idle(10);

    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R8 missing outputs actual=%0d pending expected=0", sb.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule